// File: doc/BRIEF.md
# Variable-Length SPI Frame Engine

This block is a single-lane SPI master that moves one frame of 1 to 9 bytes per chip-select assertion. The frame to send is presented MSB-aligned in a 72-bit word and goes out most significant bit first. The bits read back from the slave are collected into a shift register that fills from its least significant end. All four clock modes are available through separate polarity and phase inputs. The serial clock runs either from a 3-bit divider code that selects one of eight non-linear divide values, or from a high-speed setting that toggles the serial clock every system cycle.

A controller presents the frame, the byte count and the clock settings, then pulses `start`. `busy` stays high until the frame is done and the chip select has been released for one full serial clock period. A separate permission input decides whether the chip-select pin actually goes low. Dropping `enable` stops the engine in the next cycle, whatever it is doing.

Top module: `spi_frame_engine`

## Requirements
- R1: With `fast_mode` low, each serial clock half period lasts D system cycles, where `div_code` 0..7 gives D = 2, 4, 8, 64, 128, 1024, 2048, 4096.
- R2: With `fast_mode` high, each half period lasts exactly one system cycle, whatever `div_code` is.
- R3: While idle, `sclk` equals `cpol`. A frame of N bytes makes exactly 16*N `sclk` transitions, and `sclk` is back at `cpol` afterwards.
- R4: `mosi` carries `tx_frame` from bit 71 downward, 8*N bits. With `cpha` 0 the first bit is valid before the first edge and changes on trailing edges. With `cpha` 1 it changes on leading edges. A leading edge is one that leaves the `cpol` level.
- R5: `miso` is sampled on leading edges when `cpha` is 0 and on trailing edges when `cpha` is 1. Each sample shifts into bit 0 of `rx_data`, which is cleared at start. After a frame, bits 8*N-1..0 hold the received bits, first bit highest, and the upper bits are zero.
- R6: An `nbytes` of 0 is treated as 1, and values above 9 are treated as 9.
- R7: From the first to the last serial edge, `cs_n` is low if `cs_allow` is 1 and high if it is 0. `cs_n` is high whenever `busy` is low.
- R8: After the last edge, `cs_n` stays low for one half period. It then stays high for two half periods while `busy` is still high, and `busy` falls at the end of that interval.
- R9: A `start` seen while idle and enabled makes `busy` high in the next cycle.
- R10: When `enable` is low, the next cycle shows `busy` low, `cs_n` high and `sclk` equal to `cpol`, and `start` is ignored.
- R11: A `start` pulse during a frame has no effect on that frame.
- R12: After the synchronous reset, `busy` is 0, `cs_n` is 1, `sclk` equals `cpol` and `rx_data` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| enable | input | 1 | Engine enable; low clears and aborts |
| start | input | 1 | One-cycle request to send a frame |
| tx_frame | input | 72 | Transmit frame, MSB-aligned |
| nbytes | input | 4 | Frame length in bytes (1..9) |
| div_code | input | 3 | Serial clock divider code |
| fast_mode | input | 1 | Serial clock at system clock / 2 |
| cpol | input | 1 | Clock polarity (idle level) |
| cpha | input | 1 | Clock phase |
| cs_allow | input | 1 | Permission to drive chip select low |
| miso | input | 1 | Serial data from slave |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to slave |
| cs_n | output | 1 | Chip select, active low |
| busy | output | 1 | Frame in progress |
| rx_data | output | 72 | Received bits, last bit at bit 0 |

## Verification
The bench measures every half period against the divider table. This would catch a linear divider, or a fast mode that still followed the code. It acts as a slave in all four clock modes and checks the bit order in both directions, which exposes any sampling or shifting on the wrong edge. It also counts edges for byte counts of 0, 9 and 12, which exposes a clamp that is missing or off by one. Further tests check the chip-select hold and gap lengths, the abort on loss of enable, and a second `start` during a frame that must not restart or lengthen it.

// File: rtl/spi_fe_pkg.sv
package spi_fe_pkg;

    localparam int unsigned DIV_W = 13;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SHIFT = 2'd1,
        ST_HOLD  = 2'd2,
        ST_GAP   = 2'd3
    } seq_state_e;

    typedef struct packed {
        logic lead;
        logic trail;
    } edge_evt_t;

    // Half serial period in system cycles for a divider code.
    function automatic logic [DIV_W-1:0] half_period(input logic [2:0] code, input logic fast);
        logic [DIV_W-1:0] v;
        if (fast) begin
            v = DIV_W'(1);
        end else begin
            case (code)
                3'd0:    v = DIV_W'(2);
                3'd1:    v = DIV_W'(4);
                3'd2:    v = DIV_W'(8);
                3'd3:    v = DIV_W'(64);
                3'd4:    v = DIV_W'(128);
                3'd5:    v = DIV_W'(1024);
                3'd6:    v = DIV_W'(2048);
                default: v = DIV_W'(4096);
            endcase
        end
        return v;
    endfunction

endpackage

// File: rtl/spi_fe_rate.sv
module spi_fe_rate
    import spi_fe_pkg::*;
(
    input  logic       clk,
    input  logic       clr,
    input  logic       run,
    input  logic [2:0] div_code,
    input  logic       fast_mode,
    output logic       tick
);

    logic [DIV_W-1:0] cnt_q;
    logic [DIV_W-1:0] limit;

    assign limit = half_period(div_code, fast_mode) - DIV_W'(1);
    assign tick  = run && (cnt_q == limit);

    always_ff @(posedge clk) begin
        if (clr || !run || tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + DIV_W'(1);
        end
    end

endmodule

// File: rtl/spi_fe_seq.sv
module spi_fe_seq
    import spi_fe_pkg::*;
#(
    parameter int unsigned MAX_BYTES = 9,
    localparam int unsigned CNT_W  = $clog2(MAX_BYTES + 1),
    localparam int unsigned EDGE_W = $clog2(16 * MAX_BYTES + 1)
) (
    input  logic             clk,
    input  logic             clr,
    input  logic             start,
    input  logic             tick,
    input  logic             cpol,
    input  logic [CNT_W-1:0] nbytes,
    output logic             busy,
    output logic             cs_act,
    output logic             sclk,
    output logic             load,
    output edge_evt_t        evt
);

    seq_state_e        state_q;
    logic              sclk_q;
    logic              gap_q;
    logic [EDGE_W-1:0] edge_q;
    logic [EDGE_W-1:0] last_q;
    logic [CNT_W-1:0]  nb_eff;
    logic [EDGE_W-1:0] total_edges;

    always_comb begin
        if (nbytes == '0) begin
            nb_eff = CNT_W'(1);
        end else if (nbytes > CNT_W'(MAX_BYTES)) begin
            nb_eff = CNT_W'(MAX_BYTES);
        end else begin
            nb_eff = nbytes;
        end
    end

    assign total_edges = EDGE_W'(nb_eff) << 4;

    assign busy      = (state_q != ST_IDLE);
    assign cs_act    = (state_q == ST_SHIFT) || (state_q == ST_HOLD);
    assign sclk      = sclk_q;
    assign load      = (state_q == ST_IDLE) && start;
    assign evt.lead  = (state_q == ST_SHIFT) && tick && (sclk_q == cpol);
    assign evt.trail = (state_q == ST_SHIFT) && tick && (sclk_q != cpol);

    always_ff @(posedge clk) begin
        if (clr) begin
            state_q <= ST_IDLE;
            sclk_q  <= cpol;
            gap_q   <= 1'b0;
            edge_q  <= '0;
            last_q  <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    sclk_q <= cpol;
                    if (start) begin
                        state_q <= ST_SHIFT;
                        edge_q  <= '0;
                        last_q  <= total_edges - EDGE_W'(1);
                    end
                end
                ST_SHIFT: begin
                    if (tick) begin
                        sclk_q <= ~sclk_q;
                        edge_q <= edge_q + EDGE_W'(1);
                        if (edge_q == last_q) begin
                            state_q <= ST_HOLD;
                        end
                    end
                end
                ST_HOLD: begin
                    if (tick) begin
                        state_q <= ST_GAP;
                        gap_q   <= 1'b0;
                    end
                end
                default: begin
                    if (tick) begin
                        if (gap_q) begin
                            state_q <= ST_IDLE;
                        end else begin
                            gap_q <= 1'b1;
                        end
                    end
                end
            endcase
        end
    end

endmodule

// File: rtl/spi_fe_shift.sv
module spi_fe_shift #(
    parameter int unsigned W = 72
) (
    input  logic         clk,
    input  logic         clr,
    input  logic         load,
    input  logic [W-1:0] tx_frame,
    input  logic         out_evt,
    input  logic         samp_evt,
    input  logic         cpha,
    input  logic         miso,
    output logic         mosi,
    output logic [W-1:0] rx
);

    logic [W-1:0] tx_q;
    logic [W-1:0] rx_q;
    logic         mosi_q;

    assign mosi = mosi_q;
    assign rx   = rx_q;

    always_ff @(posedge clk) begin
        if (clr) begin
            tx_q   <= '0;
            rx_q   <= '0;
            mosi_q <= 1'b0;
        end else if (load) begin
            tx_q   <= tx_frame;
            rx_q   <= '0;
            mosi_q <= tx_frame[W-1];
        end else begin
            if (out_evt) begin
                mosi_q <= cpha ? tx_q[W-1] : tx_q[W-2];
                tx_q   <= {tx_q[W-2:0], 1'b0};
            end
            if (samp_evt) begin
                rx_q <= {rx_q[W-2:0], miso};
            end
        end
    end

endmodule

// File: rtl/spi_frame_engine.sv
module spi_frame_engine
    import spi_fe_pkg::*;
#(
    parameter int unsigned MAX_BYTES = 9,
    localparam int unsigned FRAME_W = MAX_BYTES * 8,
    localparam int unsigned CNT_W   = $clog2(MAX_BYTES + 1)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               enable,
    input  logic               start,
    input  logic [FRAME_W-1:0] tx_frame,
    input  logic [CNT_W-1:0]   nbytes,
    input  logic [2:0]         div_code,
    input  logic               fast_mode,
    input  logic               cpol,
    input  logic               cpha,
    input  logic               cs_allow,
    input  logic               miso,
    output logic               sclk,
    output logic               mosi,
    output logic               cs_n,
    output logic               busy,
    output logic [FRAME_W-1:0] rx_data
);

    logic      clr;
    logic      tick;
    logic      cs_act;
    logic      load;
    logic      out_evt;
    logic      samp_evt;
    edge_evt_t evt;

    assign clr = rst || !enable;

    spi_fe_rate u_rate (
        .clk       (clk),
        .clr       (clr),
        .run       (busy),
        .div_code  (div_code),
        .fast_mode (fast_mode),
        .tick      (tick)
    );

    spi_fe_seq #(.MAX_BYTES(MAX_BYTES)) u_seq (
        .clk    (clk),
        .clr    (clr),
        .start  (start),
        .tick   (tick),
        .cpol   (cpol),
        .nbytes (nbytes),
        .busy   (busy),
        .cs_act (cs_act),
        .sclk   (sclk),
        .load   (load),
        .evt    (evt)
    );

    // Phase picks which edge drives and which edge samples.
    assign out_evt  = cpha ? evt.lead  : evt.trail;
    assign samp_evt = cpha ? evt.trail : evt.lead;

    spi_fe_shift #(.W(FRAME_W)) u_shift (
        .clk      (clk),
        .clr      (clr),
        .load     (load),
        .tx_frame (tx_frame),
        .out_evt  (out_evt),
        .samp_evt (samp_evt),
        .cpha     (cpha),
        .miso     (miso),
        .mosi     (mosi),
        .rx       (rx_data)
    );

    assign cs_n = ~(cs_act & cs_allow);

endmodule

// File: rtl/spi_frame_engine_chk.sv
module spi_frame_engine_chk (
    input logic clk,
    input logic rst,
    input logic enable,
    input logic start,
    input logic cpol,
    input logic cs_allow,
    input logic sclk,
    input logic cs_n,
    input logic busy
);

    // R10
    abort_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !enable |=> (!busy && cs_n && (sclk == cpol)));

    // R9
    start_busy_chk: assert property (@(posedge clk) disable iff (rst)
        (enable && start && !busy) |=> busy);

    // R7
    cs_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !busy |-> cs_n);

    // R7
    edge_cs_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && (sclk != $past(sclk))) |-> (cs_n == !cs_allow));

    // R3
    idle_level_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy && $past(!busy) && $stable(cpol)) |-> (sclk == cpol));

endmodule

bind spi_frame_engine spi_frame_engine_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .enable   (enable),
    .start    (start),
    .cpol     (cpol),
    .cs_allow (cs_allow),
    .sclk     (sclk),
    .cs_n     (cs_n),
    .busy     (busy)
);

// File: tb/tb_spi_frame_engine.sv
`timescale 1ns/1ps
module tb_spi_frame_engine;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        enable = 1'b0;
    logic        start = 1'b0;
    logic [71:0] tx_frame = '0;
    logic [3:0]  nbytes = 4'd1;
    logic [2:0]  div_code = 3'd0;
    logic        fast_mode = 1'b0;
    logic        cpol = 1'b1;
    logic        cpha = 1'b0;
    logic        cs_allow = 1'b1;
    logic        miso = 1'b0;
    logic        sclk, mosi, cs_n, busy;
    logic [71:0] rx_data;

    int n_chk = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    spi_frame_engine dut (
        .clk(clk), .rst(rst), .enable(enable), .start(start),
        .tx_frame(tx_frame), .nbytes(nbytes), .div_code(div_code),
        .fast_mode(fast_mode), .cpol(cpol), .cpha(cpha), .cs_allow(cs_allow),
        .miso(miso), .sclk(sclk), .mosi(mosi), .cs_n(cs_n), .busy(busy),
        .rx_data(rx_data)
    );

    typedef struct packed {
        logic [3:0]  nb;
        logic [2:0]  code;
        logic        fast;
        logic        pol;
        logic        pha;
        logic        csen;
        logic [71:0] tx;
        logic [71:0] pat;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VEC [NV] = '{
        '{4'd1,  3'd0, 1'b0, 1'b0, 1'b0, 1'b1, 72'hA5_0000_0000_0000_0000, 72'h3C_0000_0000_0000_0000},
        '{4'd2,  3'd1, 1'b0, 1'b0, 1'b1, 1'b1, 72'h81_2300_0000_0000_0000, 72'hE7_1800_0000_0000_0000},
        '{4'd3,  3'd0, 1'b0, 1'b1, 1'b0, 1'b1, 72'h5A_C3F0_0000_0000_0000, 72'h0F_F00F_0000_0000_0000},
        '{4'd4,  3'd2, 1'b0, 1'b1, 1'b1, 1'b1, 72'hDE_ADBE_EF00_0000_0000, 72'h12_3456_7800_0000_0000},
        '{4'd9,  3'd7, 1'b1, 1'b0, 1'b0, 1'b1, 72'h01_2345_6789_ABCD_EFFE, 72'hFE_DCBA_9876_5432_1001},
        '{4'd0,  3'd0, 1'b1, 1'b1, 1'b1, 1'b1, 72'h80_0000_0000_0000_0000, 72'h7F_FFFF_FFFF_FFFF_FFFF},
        '{4'd12, 3'd0, 1'b0, 1'b0, 1'b1, 1'b1, 72'hC3_3C96_69A5_5A0F_F0E1, 72'h9A_BCDE_F012_3456_789A},
        '{4'd2,  3'd3, 1'b0, 1'b0, 1'b0, 1'b0, 72'hB7_4900_0000_0000_0000, 72'h6D_9200_0000_0000_0000},
        '{4'd1,  3'd4, 1'b0, 1'b1, 1'b0, 1'b1, 72'h96_0000_0000_0000_0000, 72'h69_0000_0000_0000_0000},
        '{4'd1,  3'd5, 1'b0, 1'b0, 1'b1, 1'b1, 72'h4E_0000_0000_0000_0000, 72'hB1_0000_0000_0000_0000}
    };

    task automatic check(input bit ok, input string req, input string what,
                         input logic [71:0] act, input logic [71:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic int clamp_nb(input logic [3:0] nb);
        if (nb == 4'd0) return 1;
        if (nb > 4'd9)  return 9;
        return int'(nb);
    endfunction

    function automatic int exp_half(input logic [2:0] code, input logic fast);
        int t [8] = '{2, 4, 8, 64, 128, 1024, 2048, 4096};
        if (fast) return 1;
        return t[code];
    endfunction

    task automatic run_vec(input vec_t v);
        int bits, hp, edges, cyc, last_edge, hmin, hmax, pidx, hold_cnt, gap_cnt;
        logic prev;
        logic [71:0] cap, exp_tx, exp_rx;
        bit cs_bad, cs_low_any;
        string rq_len, rq_rate;
        bits = 8 * clamp_nb(v.nb);
        hp   = exp_half(v.code, v.fast);
        rq_len  = (v.nb == 4'd0 || v.nb > 4'd9) ? "R6" : "R3";
        rq_rate = v.fast ? "R2" : "R1";
        nbytes = v.nb; div_code = v.code; fast_mode = v.fast;
        cpol = v.pol; cpha = v.pha; cs_allow = v.csen;
        tx_frame = v.tx; miso = v.pat[71];
        @(negedge clk);
        @(negedge clk);
        check(sclk == v.pol, "R3", "idle sclk level", 72'(sclk), 72'(v.pol));
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(busy == 1'b1, "R9", "busy after start", 72'(busy), 72'd1);
        prev = sclk; edges = 0; cyc = 0; last_edge = 0; hmin = 1 << 30; hmax = 0;
        pidx = v.pha ? 0 : 1; hold_cnt = 0; gap_cnt = 0; cap = '0;
        cs_bad = 1'b0; cs_low_any = 1'b0;
        while (busy && cyc < 100000) begin
            @(negedge clk);
            cyc++;
            if (sclk !== prev) begin
                edges++;
                if (edges > 1) begin
                    if (cyc - last_edge < hmin) hmin = cyc - last_edge;
                    if (cyc - last_edge > hmax) hmax = cyc - last_edge;
                end
                last_edge = cyc;
                if ((prev == v.pol) != v.pha) begin
                    cap = {cap[70:0], mosi};
                end else begin
                    if (pidx < 72) miso = v.pat[71-pidx];
                    pidx++;
                end
                prev = sclk;
            end
            if (!cs_n) cs_low_any = 1'b1;
            if (busy && edges >= 1 && edges < 2*bits && (cs_n !== !v.csen)) cs_bad = 1'b1;
            if (busy && edges == 2*bits) begin
                if (cs_n) gap_cnt++;
                else      hold_cnt++;
            end
        end
        exp_tx = v.tx  >> (72 - bits);
        exp_rx = v.pat >> (72 - bits);
        check(edges == 2*bits, rq_len, "sclk edge count", 72'(edges), 72'(2*bits));
        check(hmin == hp && hmax == hp, rq_rate, "half period", 72'(hmax), 72'(hp));
        check(cap == exp_tx, "R4", "mosi bits", cap, exp_tx);
        check(rx_data == exp_rx, "R5", "rx_data", rx_data, exp_rx);
        if (v.csen) begin
            check(!cs_bad, "R7", "cs_n low during frame", 72'(cs_bad), 72'd0);
            check(hold_cnt == hp, "R8", "cs hold cycles", 72'(hold_cnt), 72'(hp));
            check(gap_cnt == 2*hp, "R8", "cs gap cycles", 72'(gap_cnt), 72'(2*hp));
        end else begin
            check(!cs_low_any, "R7", "cs_n stays high", 72'(cs_low_any), 72'd0);
        end
        check(!busy && cs_n && sclk == v.pol, "R3", "idle after frame",
              72'({busy, cs_n, sclk}), 72'({1'b0, 1'b1, v.pol}));
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        int e2, c2;
        logic p2;
        // R12: reset state
        repeat (4) @(negedge clk);
        check(!busy && cs_n && sclk == 1'b1 && rx_data == '0, "R12", "reset state",
              72'({busy, cs_n, sclk}), 72'({1'b0, 1'b1, 1'b1}));
        rst = 1'b0;
        enable = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            run_vec(VEC[i]);
        end

        // R10: abort mid-frame by dropping enable
        nbytes = 4'd4; div_code = 3'd1; fast_mode = 1'b0; cpol = 1'b1; cpha = 1'b0;
        cs_allow = 1'b1; tx_frame = 72'hFF_FF00_0000_0000_0000;
        @(negedge clk);
        start = 1'b1; @(negedge clk); start = 1'b0;
        repeat (21) @(negedge clk);
        check(busy, "R10", "busy before abort", 72'(busy), 72'd1);
        enable = 1'b0;
        @(negedge clk);
        check(!busy && cs_n && sclk == 1'b1, "R10", "state after abort",
              72'({busy, cs_n, sclk}), 72'({1'b0, 1'b1, 1'b1}));
        start = 1'b1; @(negedge clk); start = 1'b0;
        repeat (4) @(negedge clk);
        check(!busy && cs_n, "R10", "start ignored while disabled",
              72'({busy, cs_n}), 72'({1'b0, 1'b1}));
        enable = 1'b1;
        @(negedge clk);

        // R11: second start during a frame
        nbytes = 4'd1; fast_mode = 1'b1; cpol = 1'b0; cpha = 1'b0;
        @(negedge clk);
        start = 1'b1; @(negedge clk); start = 1'b0;
        p2 = sclk; e2 = 0; c2 = 0;
        repeat (3) begin
            @(negedge clk);
            if (sclk !== p2) begin e2++; p2 = sclk; end
        end
        nbytes = 4'd9;
        start = 1'b1; @(negedge clk); start = 1'b0;
        if (sclk !== p2) begin e2++; p2 = sclk; end
        while (busy && c2 < 1000) begin
            @(negedge clk);
            c2++;
            if (sclk !== p2) begin e2++; p2 = sclk; end
        end
        check(e2 == 16, "R11", "edges with restart attempt", 72'(e2), 72'd16);
        repeat (3) @(negedge clk);
        check(!busy, "R11", "no second frame", 72'(busy), 72'd0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule